// File: doc/BRIEF.md
# Free-Running 64-bit Cycle Counter with Torn-Read Detection

This block holds a wide cycle counter that software reaches over a 32-bit register port. Three registers are decoded: a control/status word, the low part of the count and the high part of the count. Setting bit 0 of the control word starts the counter, which then advances by one on every clock. Clearing that bit stops it, and the counter keeps its value.

The count is wider than the bus, so software reads it in a fixed order: the low word, then the high word, then the control word. Reading the low word copies the whole count into a snapshot and arms a consistency flag. The high word returns the upper part of that snapshot. The flag appears in the top bit of the control word. It drops if the low part of the live counter carries into the upper part before the control read. It also drops if the `flushEvt` input pulses, as an interrupt would. When software sees the flag at 0, it repeats the sequence.

The widths are parameters. `CNT_W` sets the counter width and `LOW_W` sets the width of the low word, with defaults of 64 and 32.

Top module: `cyc64_snap`

## Requirements
- R1: The control word is at address 0x103, the low word at 0x104 and the high word at 0x105. `rdData` is combinational and reflects `rdEn`/`addr` in the same cycle. It is all zero when `rdEn` is low or the address matches none of the three.
- R2: A write (`wrEn` high, `addr` 0x103) loads `wrData[0]` into the enable bit at the next rising edge. While the enable bit is 1, the counter increases by one at every rising edge and wraps modulo 2^CNT_W.
- R3: While the enable bit is 0, the counter holds its value.
- R4: A read of 0x104 returns counter bits [LOW_W-1:0], zero-extended, as the counter stands in that cycle. At the edge that ends the read, the full count is copied into the snapshot.
- R5: A read of 0x105 returns snapshot bits [CNT_W-1:LOW_W], zero-extended. The live counter has no effect on this value.
- R6: A read of 0x103 returns the enable bit in bit 0 and the consistency flag in bit 31. All other bits are zero.
- R7: A low-word read sets the consistency flag to 1 at the next edge.
- R8: If the counter is enabled and its low LOW_W bits are all ones at an edge, so that a carry crosses into the upper part, the flag clears at that edge. The exception is a low-word read in that same cycle, which sets the flag instead.
- R9: A high level on `flushEvt` clears the flag at the next edge. This takes priority over a low-word read in the same cycle.
- R10: While `rstN` is low, and just after it rises, the counter, snapshot, enable bit and flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read strobe for this cycle |
| wrEn | input | 1 | Write strobe for this cycle |
| addr | input | 12 | Register address |
| wrData | input | 32 | Write data |
| flushEvt | input | 1 | Pulse that invalidates the consistency flag |
| rdData | output | 32 | Read data, combinational |

## Verification
Read data is due in the same cycle as the read strobe. Effects on the enable bit, the count, the snapshot and the flag become visible one rising edge after the access that causes them. The bench sets its inputs on the falling edge and compares `rdData` against a behavioural model 8 ns later, just before the next rising edge. The model advances at the rising edges from the same inputs, so every expected value carries the one-edge delay. The bench runs with a narrow low word so that carries come every few dozen cycles. Read sequences are stretched over gaps of growing length so that some of them straddle a carry and some land with the low read on the carry cycle itself.

// File: rtl/cyc64_pkg.sv
package cyc64_pkg;
  localparam int ADDR_W = 12;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 12'h103;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 12'h104;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 12'h105;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic cntEn;     // advance the counter at this edge
    logic snapLoad;  // copy the count into the snapshot
    logic selLow;    // drive the low word onto the read bus
    logic selHigh;   // drive the snapshot upper part
    logic selCtrl;   // drive the status word
  } cyc64_stb_t;
endpackage

// File: rtl/cyc64_ctrl.sv
module cyc64_ctrl
  import cyc64_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit,
  input  logic              flushEvt,
  input  logic              carryNext,
  output cyc64_stb_t        stb,
  output logic              enQ,
  output logic              flagQ
);
  logic hitCtrl, hitLow, hitHigh;
  logic lowRd, ctrlWr;

  assign hitCtrl = (addr == ADDR_CTRL);
  assign hitLow  = (addr == ADDR_LOW);
  assign hitHigh = (addr == ADDR_HIGH);
  assign lowRd   = rdEn && hitLow;
  assign ctrlWr  = wrEn && hitCtrl;

  always_comb begin
    stb          = '0;
    stb.cntEn    = enQ;
    stb.snapLoad = lowRd;
    stb.selLow   = lowRd;
    stb.selHigh  = rdEn && hitHigh;
    stb.selCtrl  = rdEn && hitCtrl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ <= wrBit;
    end
  end

  // priority: flush, then low read, then carry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (flushEvt) begin
      flagQ <= 1'b0;
    end else if (lowRd) begin
      flagQ <= 1'b1;
    end else if (carryNext) begin
      flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/cyc64_dp.sv
module cyc64_dp
  import cyc64_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cyc64_stb_t       stb,
  input  logic             enQ,
  input  logic             flagQ,
  output logic             carryNext,
  output logic [CNT_W-1:0] cntQ,
  output logic [BUS_W-1:0] rdData
);
  localparam int HIGH_W = CNT_W - LOW_W;

  logic [CNT_W-1:0] snapQ;

  assign carryNext = stb.cntEn && (&cntQ[LOW_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (stb.cntEn) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ <= '0;
    end else if (stb.snapLoad) begin
      snapQ <= cntQ;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.selLow) begin
      rdData[LOW_W-1:0] = cntQ[LOW_W-1:0];
    end
    if (stb.selHigh) begin
      rdData[HIGH_W-1:0] = snapQ[CNT_W-1:LOW_W];
    end
    if (stb.selCtrl) begin
      rdData[BUS_W-1] = flagQ;
      rdData[0]       = enQ;
    end
  end
endmodule

// File: rtl/cyc64_snap.sv
module cyc64_snap
  import cyc64_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              flushEvt,
  output logic [BUS_W-1:0]  rdData
);
  cyc64_stb_t       stb;
  logic             enQ;
  logic             flagQ;
  logic             carryNext;
  logic [CNT_W-1:0] cntQ;

  cyc64_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrBit     (wrData[0]),
    .flushEvt  (flushEvt),
    .carryNext (carryNext),
    .stb       (stb),
    .enQ       (enQ),
    .flagQ     (flagQ)
  );

  cyc64_dp #(.CNT_W(CNT_W), .LOW_W(LOW_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .enQ       (enQ),
    .flagQ     (flagQ),
    .carryNext (carryNext),
    .cntQ      (cntQ),
    .rdData    (rdData)
  );
endmodule

// File: rtl/cyc64_chk.sv
module cyc64_chk
  import cyc64_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              flushEvt,
  input logic              enQ,
  input logic              flagQ,
  input logic [CNT_W-1:0]  cntQ
);
  logic lowRead;
  assign lowRead = rdEn && (addr == ADDR_LOW);

  a_r2_counts_up: assert property (@(posedge clk) disable iff (!rstN)
    enQ |=> cntQ == CNT_W'($past(cntQ) + 1'b1));

  a_r3_holds_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> $stable(cntQ));

  a_r7_low_read_arms: assert property (@(posedge clk) disable iff (!rstN)
    (lowRead && !flushEvt) |=> flagQ);

  a_r8_carry_tears: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && (&cntQ[LOW_W-1:0]) && !lowRead) |=> !flagQ);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushEvt |=> !flagQ);
endmodule

bind cyc64_snap cyc64_chk #(.CNT_W(CNT_W), .LOW_W(LOW_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .rdEn     (rdEn),
  .addr     (addr),
  .flushEvt (flushEvt),
  .enQ      (enQ),
  .flagQ    (flagQ),
  .cntQ     (cntQ)
);

// File: tb/cyc64_snap_tb_top.sv
module cyc64_snap_tb_top;
  localparam int CNT_W = 12;
  localparam int LOW_W = 6;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LOW  = 12'h104;
  localparam logic [11:0] A_HIGH = 12'h105;
  localparam longint unsigned CNT_MASK = (64'd1 << CNT_W) - 1;
  localparam longint unsigned LOW_MASK = (64'd1 << LOW_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        flushEvt = 1'b0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R10";

  // behavioural model
  longint unsigned mCnt = 0;
  longint unsigned mSnap = 0;
  bit mEn = 1'b0;
  bit mFlag = 1'b0;

  always #10 clk = ~clk;

  cyc64_snap #(.CNT_W(CNT_W), .LOW_W(LOW_W)) dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .flushEvt(flushEvt), .rdData(rdData)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mSnap = 0; mEn = 0; mFlag = 0;
    end else begin
      bit isLow;
      bit nFlag;
      isLow = rdEn && addr == A_LOW;
      nFlag = mFlag;
      if (mEn && (mCnt & LOW_MASK) == LOW_MASK) nFlag = 0;
      if (isLow) begin nFlag = 1; mSnap = mCnt; end
      if (flushEvt) nFlag = 0;
      if (mEn) mCnt = (mCnt + 1) & CNT_MASK;
      if (wrEn && addr == A_CTRL) mEn = wrData[0];
      mFlag = nFlag;
    end
  end

  function automatic logic [31:0] expRead();
    logic [31:0] v = '0;
    if (rdEn) begin
      if (addr == A_LOW) v = 32'(mCnt & LOW_MASK);
      else if (addr == A_HIGH) v = 32'(mSnap >> LOW_W);
      else if (addr == A_CTRL) begin v[31] = mFlag; v[0] = mEn; end
    end
    return v;
  endfunction

  function automatic string baseTag();
    if (!rstN) return "R10";
    if (!rdEn) return "R1";
    if (addr == A_LOW) return "R4";
    if (addr == A_HIGH) return "R5";
    if (addr == A_CTRL) return "R6";
    return "R1";
  endfunction

  // compare on every clock, just before the rising edge
  always begin
    @(negedge clk);
    #8;
    if (!done) begin
      logic [31:0] e;
      e = expRead();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s/%s addr=%h rd=%0b actual=%h expected=%h",
                 baseTag(), phase, addr, rdEn, rdData, e);
      end
    end
  end

  task automatic step(input bit rd, input bit wr, input logic [11:0] a,
                      input logic [31:0] d, input bit fl);
    @(negedge clk);
    rdEn = rd; wrEn = wr; addr = a; wrData = d; flushEvt = fl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 12'h0, 32'h0, 0);
  endtask

  task automatic readSeq(input int gap, input bit flushMid);
    step(1, 0, A_LOW, 0, 0);
    for (int i = 0; i < gap; i++) step(0, 0, 12'h0, 0, flushMid && i == 0);
    step(1, 0, A_HIGH, 0, 0);
    step(1, 0, A_CTRL, 0, 0);
  endtask

  initial begin
    // R10: reset state seen through the control and data words
    step(1, 0, A_CTRL, 0, 0);
    step(1, 0, A_LOW, 0, 0);
    step(1, 0, A_HIGH, 0, 0);
    @(negedge clk); rstN = 1'b1;
    step(1, 0, A_CTRL, 0, 0);
    // R3: disabled counter holds; R1: unmapped address reads zero
    phase = "R3";
    idle(5);
    step(1, 0, A_LOW, 0, 0);
    step(1, 0, 12'h106, 0, 0);
    step(1, 0, 12'h102, 0, 0);
    // R2: enable, then watch the count advance
    phase = "R2";
    step(0, 1, A_CTRL, 32'h1, 0);
    step(1, 0, A_CTRL, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, A_LOW, 0, 0);
    // R7 / R8: read sequences with growing gaps, some straddle a carry
    phase = "R8";
    for (int g = 0; g < 70; g++) readSeq(g, 0);
    // R8: low read landing exactly on the carry cycle
    for (int k = 0; k < 66; k++) begin
      phase = "R7";
      readSeq(0, 0);
      step(1, 0, A_LOW, 0, 0);
      step(1, 0, A_CTRL, 0, 0);
    end
    // R9: flush between low and control read, and on the low read itself
    phase = "R9";
    for (int g = 1; g < 5; g++) readSeq(g, 1);
    step(1, 0, A_LOW, 0, 1);
    step(1, 0, A_CTRL, 0, 0);
    // R3: disable and confirm the count stays put
    phase = "R3";
    step(0, 1, A_CTRL, 32'h0, 0);
    idle(3);
    for (int i = 0; i < 4; i++) readSeq(i, 0);
    idle(70);
    step(1, 0, A_CTRL, 0, 0);
    // R2: re-enable keeps the old count
    phase = "R2";
    step(0, 1, A_CTRL, 32'hFFFF_FFFF, 0);
    for (int i = 0; i < 5; i++) readSeq(i, 0);
    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule